// File: doc/BRIEF.md
# Slack-Driven Clock Divisor and Supply Code Selector

This block chooses, at every timeslot boundary of a hard real-time task, how far the processor clock can be slowed and which supply-voltage code goes with that speed. Software first loads the task's parameters through a small write-only register port. These are the whole-task worst-case time, one worst-case time per slot, the cost of changing speed, a limit on the largest divisor, and a table of voltage codes indexed by divisor. All times are counted in base-clock cycles.

While the task runs, the block keeps a base-rate count of elapsed time. Each executed cycle at divisor j adds j to the count. At a slot boundary, the block forms the remaining budget for that slot. It then tries the divisors one per cycle, starting with the slowest allowed. It reports the first divisor whose worst-case estimate fits the budget, with a one-cycle valid pulse. The speed-change cost is charged against a candidate only when that candidate differs from the divisor currently in use. If no divisor fits, the block falls back to full speed and raises a risk flag.

Top module: `hop_divisor_sel`

## Requirements
- R1: During and after a synchronous reset, `dec_valid`, `dec_risk`, `busy` and `acc_time` are 0, `dec_div` is 1, and the divisor limit is MAXDIV.
- R2: Each cycle with `div_tick` high adds the divisor in use to `acc_time`, which saturates at its all-ones value. `task_start` clears `acc_time`, makes divisor 1 the one in use, and cancels any search in progress. The divisor in use is 1 after reset and otherwise the last one decided.
- R3: For slot i the budget is the total worst-case time minus slot i's worst-case time, minus `acc_time` as sampled at the strobe, minus the change cost. It is computed as a signed value, so it may be negative.
- R4: The estimate for divisor j is slot i's worst-case time times j. The change cost is added only when j differs from the divisor in use.
- R5: The decided divisor is the largest j, with 1 <= j <= limit, whose estimate is less than or equal to the budget.
- R6: If no candidate fits, `dec_div` is 1 and `dec_risk` is 1. Otherwise `dec_risk` is 0.
- R7: `dec_vcode` equals the voltage table entry stored for the decided divisor (entry index = divisor - 1). The decision outputs hold their values until the next decision.
- R8: A write of 0 to the limit register sets it to 1, and a value above MAXDIV sets it to MAXDIV. The limit can therefore be set to 2 to restrict the choice to full and half speed.
- R9: If `slot_go` is sampled at edge E0 while idle, `busy` is high from E0 and `dec_valid` pulses for exactly one cycle after edge E0+m. Here m = limit - decided + 1 when a candidate fits, and m = limit when none does.
- R10: A `slot_go` sampled while `busy` is high is ignored. No second decision is made and the current one is unchanged.
- R11: Configuration address: the two top bits select a region and the low bits give an index. Region 0 holds index 0 = total time, index 1 = change cost, index 2 = divisor limit. Region 1 holds slot times, indexed by slot. Region 2 holds voltage codes, indexed by divisor - 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW (8) | Region (top 2 bits) and index |
| cfg_wdata | input | TW (20) | Configuration write data |
| task_start | input | 1 | Start of a new task instance |
| div_tick | input | 1 | One executed cycle at the current divisor |
| slot_go | input | 1 | Slot boundary strobe |
| slot_idx | input | SW (4) | Slot about to start |
| busy | output | 1 | Search in progress |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_div | output | DW (3) | Decided clock divisor |
| dec_vcode | output | VW (4) | Supply-voltage code for the decided divisor |
| dec_risk | output | 1 | No candidate met the budget |
| acc_time | output | TW (20) | Elapsed base-clock time of the task |

## Verification
`acc_time` changes on the edge that samples `div_tick` or `task_start`, so the bench reads it at the following falling edge. A decision appears m edges after the edge that sampled the strobe, where m counts the candidates examined. The bench predicts m from its own model of the budget and the scan order. It counts falling edges from the strobe until `dec_valid`, then compares that count with m + 1 and compares divisor, code and flag in that same cycle. It then confirms that the pulse is gone one cycle later and that a strobe given while busy produces no extra decision.

// File: rtl/hop_pkg.sv
`timescale 1ns/1ps
package hop_pkg;
  typedef enum logic {S_IDLE, S_SCAN} hop_state_e;
  localparam logic [1:0] REGION_SCALAR = 2'd0;
  localparam logic [1:0] REGION_SLOT   = 2'd1;
  localparam logic [1:0] REGION_VOLT   = 2'd2;
endpackage

// File: rtl/hop_cfg_regs.sv
`timescale 1ns/1ps
module hop_cfg_regs #(
  parameter int TW     = 20,
  parameter int SLOTS  = 16,
  parameter int MAXDIV = 4,
  parameter int VW     = 4,
  parameter int AW     = 8,
  localparam int SW    = $clog2(SLOTS),
  localparam int DW    = $clog2(MAXDIV + 1),
  localparam int VAW   = (MAXDIV > 1) ? $clog2(MAXDIV) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [TW-1:0]  cfg_wdata,
  input  logic           slot_re,
  input  logic [SW-1:0]  slot_ra,
  output logic [TW-1:0]  wc_q,
  input  logic           vt_re,
  input  logic [VAW-1:0] vt_ra,
  output logic [VW-1:0]  vt_q,
  output logic [TW-1:0]  total_q,
  output logic [TW-1:0]  td_q,
  output logic [DW-1:0]  jlim_q
);
  import hop_pkg::*;
  localparam int IW = AW - 2;

  logic [1:0]    region;
  logic [IW-1:0] idx;
  logic [TW-1:0] slot_mem [SLOTS];
  logic [VW-1:0] volt_mem [MAXDIV];

  assign region = cfg_addr[AW-1 -: 2];
  assign idx    = cfg_addr[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      total_q <= '0;
      td_q    <= '0;
      jlim_q  <= DW'(MAXDIV);
    end else if (cfg_we && region == REGION_SCALAR) begin
      case (idx)
        IW'(0): total_q <= cfg_wdata;
        IW'(1): td_q    <= cfg_wdata;
        IW'(2): begin
          if (cfg_wdata == '0)                jlim_q <= DW'(1);
          else if (cfg_wdata > TW'(MAXDIV))   jlim_q <= DW'(MAXDIV);
          else                                jlim_q <= cfg_wdata[DW-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we && region == REGION_SLOT && idx < IW'(SLOTS))
      slot_mem[idx[SW-1:0]] <= cfg_wdata;
    if (slot_re)
      wc_q <= slot_mem[slot_ra];
  end

  always_ff @(posedge clk) begin
    if (cfg_we && region == REGION_VOLT && idx < IW'(MAXDIV))
      volt_mem[idx[VAW-1:0]] <= cfg_wdata[VW-1:0];
    if (vt_re)
      vt_q <= volt_mem[vt_ra];
  end
endmodule

// File: rtl/hop_time_acc.sv
`timescale 1ns/1ps
module hop_time_acc #(
  parameter int TW = 20,
  parameter int DW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  input  logic [DW-1:0] cur_div,
  output logic [TW-1:0] acc
);
  logic [TW:0] sum;
  assign sum = {1'b0, acc} + (TW+1)'(cur_div);

  always_ff @(posedge clk) begin
    if (rst || clr)  acc <= '0;
    else if (tick)   acc <= sum[TW] ? '1 : sum[TW-1:0];
  end
endmodule

// File: rtl/hop_search.sv
`timescale 1ns/1ps
module hop_search #(
  parameter int TW     = 20,
  parameter int MAXDIV = 4,
  localparam int DW    = $clog2(MAXDIV + 1),
  localparam int VAW   = (MAXDIV > 1) ? $clog2(MAXDIV) : 1,
  localparam int EW    = TW + DW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           abort,
  input  logic [TW-1:0]  total,
  input  logic [TW-1:0]  td,
  input  logic [DW-1:0]  jlim,
  input  logic [TW-1:0]  wc,
  input  logic [TW-1:0]  acc,
  output logic           accept,
  output logic           busy,
  output logic           vt_re,
  output logic [VAW-1:0] vt_ra,
  output logic [DW-1:0]  prev_div,
  output logic           dec_valid,
  output logic [DW-1:0]  dec_div,
  output logic           dec_risk
);
  import hop_pkg::*;

  hop_state_e        state;
  logic [DW-1:0]     j;
  logic [TW-1:0]     acc_snap;
  logic signed [EW-1:0] budget;
  logic [EW-1:0]     est;
  logic              fits, done;

  assign busy   = (state == S_SCAN);
  assign accept = go && !busy && !abort;

  assign budget = $signed(EW'(total)) - $signed(EW'(wc))
                - $signed(EW'(acc_snap)) - $signed(EW'(td));
  assign est    = EW'(wc) * EW'(j) + ((j != prev_div) ? EW'(td) : '0);
  assign fits   = $signed(est) <= budget;
  assign done   = busy && (fits || j == DW'(1));
  assign vt_re  = done && !abort;
  assign vt_ra  = fits ? VAW'(j - DW'(1)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      j         <= DW'(1);
      acc_snap  <= '0;
      prev_div  <= DW'(1);
      dec_valid <= 1'b0;
      dec_div   <= DW'(1);
      dec_risk  <= 1'b0;
    end else begin
      dec_valid <= 1'b0;
      if (abort) begin
        state    <= S_IDLE;
        prev_div <= DW'(1);
      end else if (accept) begin
        state    <= S_SCAN;
        j        <= jlim;
        acc_snap <= acc;
      end else if (done) begin
        state     <= S_IDLE;
        dec_valid <= 1'b1;
        dec_div   <= fits ? j : DW'(1);
        prev_div  <= fits ? j : DW'(1);
        dec_risk  <= !fits;
      end else if (busy) begin
        j <= j - DW'(1);
      end
    end
  end
endmodule

// File: rtl/hop_divisor_sel.sv
`timescale 1ns/1ps
module hop_divisor_sel #(
  parameter int TW     = 20,
  parameter int SLOTS  = 16,
  parameter int MAXDIV = 4,
  parameter int VW     = 4,
  parameter int AW     = 8,
  localparam int SW    = $clog2(SLOTS),
  localparam int DW    = $clog2(MAXDIV + 1),
  localparam int VAW   = (MAXDIV > 1) ? $clog2(MAXDIV) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [TW-1:0] cfg_wdata,
  input  logic          task_start,
  input  logic          div_tick,
  input  logic          slot_go,
  input  logic [SW-1:0] slot_idx,
  output logic          busy,
  output logic          dec_valid,
  output logic [DW-1:0] dec_div,
  output logic [VW-1:0] dec_vcode,
  output logic          dec_risk,
  output logic [TW-1:0] acc_time
);
  logic [TW-1:0]  wc_q, total_q, td_q;
  logic [DW-1:0]  jlim_q, prev_div;
  logic           accept, vt_re;
  logic [VAW-1:0] vt_ra;

  hop_cfg_regs #(.TW(TW), .SLOTS(SLOTS), .MAXDIV(MAXDIV), .VW(VW), .AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .slot_re(accept), .slot_ra(slot_idx), .wc_q(wc_q),
    .vt_re(vt_re), .vt_ra(vt_ra), .vt_q(dec_vcode),
    .total_q(total_q), .td_q(td_q), .jlim_q(jlim_q)
  );

  hop_time_acc #(.TW(TW), .DW(DW)) u_acc (
    .clk(clk), .rst(rst), .clr(task_start), .tick(div_tick),
    .cur_div(prev_div), .acc(acc_time)
  );

  hop_search #(.TW(TW), .MAXDIV(MAXDIV)) u_search (
    .clk(clk), .rst(rst), .go(slot_go), .abort(task_start),
    .total(total_q), .td(td_q), .jlim(jlim_q), .wc(wc_q), .acc(acc_time),
    .accept(accept), .busy(busy), .vt_re(vt_re), .vt_ra(vt_ra),
    .prev_div(prev_div), .dec_valid(dec_valid), .dec_div(dec_div), .dec_risk(dec_risk)
  );
endmodule

// File: rtl/hop_divisor_sel_chk.sv
`timescale 1ns/1ps
module hop_divisor_sel_chk #(
  parameter int TW     = 20,
  parameter int MAXDIV = 4,
  parameter int DW     = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          task_start,
  input logic          slot_go,
  input logic          busy,
  input logic          dec_valid,
  input logic [DW-1:0] dec_div,
  input logic          dec_risk,
  input logic [TW-1:0] acc_time
);
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> !busy);
  p_div_range_r5: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_div >= DW'(1) && dec_div <= DW'(MAXDIV)));
  p_risk_full_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_risk) |-> dec_div == DW'(1));
  p_busy_from_go_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(slot_go));
  p_acc_clear_r2: assert property (@(posedge clk) disable iff (rst)
    task_start |=> acc_time == '0);
  p_acc_mono_r2: assert property (@(posedge clk) disable iff (rst)
    !task_start |=> acc_time >= $past(acc_time));
endmodule

bind hop_divisor_sel hop_divisor_sel_chk #(.TW(TW), .MAXDIV(MAXDIV), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .task_start(task_start), .slot_go(slot_go), .busy(busy),
  .dec_valid(dec_valid), .dec_div(dec_div), .dec_risk(dec_risk), .acc_time(acc_time)
);

// File: tb/test_hop_divisor_sel.sv
`timescale 1ns/1ps
module test_hop_divisor_sel;
  localparam int TW = 20, SLOTS = 16, MAXDIV = 4, VW = 4, AW = 8;
  localparam int SW = $clog2(SLOTS), DW = $clog2(MAXDIV + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [TW-1:0] cfg_wdata = '0;
  logic task_start = 1'b0, div_tick = 1'b0, slot_go = 1'b0;
  logic [SW-1:0] slot_idx = '0;
  logic busy, dec_valid, dec_risk;
  logic [DW-1:0] dec_div;
  logic [VW-1:0] dec_vcode;
  logic [TW-1:0] acc_time;

  int checks = 0, failures = 0;
  longint m_total, m_td, m_acc, m_prev, m_jlim;
  longint m_wc [SLOTS];
  longint m_vt [MAXDIV];

  always #4 clk = ~clk;

  hop_divisor_sel #(.TW(TW), .SLOTS(SLOTS), .MAXDIV(MAXDIV), .VW(VW), .AW(AW)) i_hop_divisor_sel (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .task_start(task_start), .div_tick(div_tick), .slot_go(slot_go), .slot_idx(slot_idx),
    .busy(busy), .dec_valid(dec_valid), .dec_div(dec_div), .dec_vcode(dec_vcode),
    .dec_risk(dec_risk), .acc_time(acc_time)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R11 address layout: region in top two bits, index below
  task automatic cfg_write(input int region, input int idx, input longint data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'((region << (AW - 2)) | idx); cfg_wdata = TW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_total(input longint v); cfg_write(0, 0, v); m_total = v; endtask
  task automatic set_td(input longint v);    cfg_write(0, 1, v); m_td = v; endtask
  task automatic set_slot(input int i, input longint v); cfg_write(1, i, v); m_wc[i] = v; endtask
  task automatic set_lim(input longint v);   // R8 clamping model
    cfg_write(0, 2, v);
    m_jlim = (v == 0) ? 1 : (v > MAXDIV) ? MAXDIV : v;
  endtask

  task automatic start_task;
    @(negedge clk); task_start = 1'b1;
    @(negedge clk); task_start = 1'b0;
    m_acc = 0; m_prev = 1;
    check(acc_time == '0, "R2 clear", acc_time, 0);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); div_tick = 1'b1;
      m_acc = m_acc + m_prev;
      if (m_acc > (1 << TW) - 1) m_acc = (1 << TW) - 1;
    end
    @(negedge clk); div_tick = 1'b0;
    check(acc_time == TW'(m_acc), "R2 accumulate", acc_time, m_acc);
  endtask

  // R3/R4/R5/R6/R7/R9/R10: predict and compare one decision
  task automatic run_slot(input int i, input bit dup, input string tag);
    longint budget, est, e_div, e_m, e_risk;
    int cnt;
    budget = m_total - m_wc[i] - m_acc - m_td;
    e_div = 1; e_risk = 1; e_m = m_jlim;
    for (longint jj = m_jlim; jj >= 1; jj--) begin
      est = m_wc[i] * jj + ((jj != m_prev) ? m_td : 0);
      if (est <= budget) begin
        e_div = jj; e_risk = 0; e_m = m_jlim - jj + 1;
        break;
      end
    end
    @(negedge clk); slot_go = 1'b1; slot_idx = SW'(i);
    @(negedge clk); slot_go = dup; slot_idx = SW'((i + 1) % SLOTS); cnt = 1;
    while (!dec_valid && cnt < 40) begin
      @(negedge clk); slot_go = 1'b0; cnt++;
    end
    slot_go = 1'b0;
    check(dec_valid == 1'b1, {tag, " R9 valid seen"}, dec_valid, 1);
    check(cnt == e_m + 1, {tag, " R9 latency"}, cnt, e_m + 1);
    check(dec_div == DW'(e_div), {tag, " R5 divisor"}, dec_div, e_div);
    check(dec_risk == e_risk[0], {tag, " R6 risk"}, dec_risk, e_risk);
    check(dec_vcode == VW'(m_vt[e_div - 1]), {tag, " R7 vcode"}, dec_vcode, m_vt[e_div - 1]);
    @(negedge clk);
    check(dec_valid == 1'b0, {tag, " R9 single pulse"}, dec_valid, 0);
    if (dup) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        check(!dec_valid && !busy, {tag, " R10 ignored strobe"}, dec_valid, 0);
      end
      check(dec_div == DW'(e_div), {tag, " R7 R10 held"}, dec_div, e_div);
    end
    m_prev = e_div;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_jlim = MAXDIV; m_prev = 1; m_acc = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(dec_valid == 1'b0 && busy == 1'b0, "R1 valid/busy", {dec_valid, busy}, 0);
    check(dec_div == DW'(1) && dec_risk == 1'b0, "R1 div/risk", dec_div, 1);
    check(acc_time == '0, "R1 acc", acc_time, 0);
    rst = 1'b0;
    for (int k = 0; k < MAXDIV; k++) begin
      cfg_write(2, k, k * 3 + 1); m_vt[k] = k * 3 + 1;
    end
    set_total(1000); set_td(10);
    set_slot(0, 100); set_slot(1, 300); set_slot(2, 315); set_slot(3, 600);
    for (int k = 4; k < SLOTS; k++) set_slot(k, 50 * k);
    start_task;
    run_slot(0, 1'b0, "R5 slowest fits");       // div 4, R1 limit default
    ticks(5);                                   // R2: +4 each
    run_slot(1, 1'b0, "R3 budget");             // div 2
    ticks(10);                                  // R2: +2 each
    run_slot(2, 1'b0, "R4 no penalty same div"); // div 2 only without penalty
    run_slot(3, 1'b0, "R6 no fit");             // risk
    run_slot(1, 1'b1, "R10 busy");
    set_lim(2);                                 // R8 full/half only
    start_task;
    run_slot(0, 1'b0, "R8 limit 2");
    set_lim(0);
    run_slot(0, 1'b0, "R8 limit 0 -> 1");
    set_lim(9);
    run_slot(0, 1'b0, "R8 limit clamp");
    for (int it = 0; it < 60; it++) begin
      if ($urandom_range(4) == 0) start_task;
      if ($urandom_range(3) == 0) begin
        set_total($urandom_range(20000));
        set_td($urandom_range(200));
        set_lim($urandom_range(MAXDIV + 1));
      end
      if ($urandom_range(1) == 0) set_slot(it % SLOTS, $urandom_range(3000, 1));
      ticks($urandom_range(20));
      run_slot($urandom_range(SLOTS - 1), it % 7 == 0, "random");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule